// File: doc/BRIEF.md
# Double-Buffered Side-Band Packet Store

This block holds the side-band packets that a display stream transmitter inserts into its output. Software programs the packets through a small register port. It first loads a word pointer, then streams words through a data register that moves the pointer forward after each write. The words land in a shadow memory. The transmitter never sees the shadow memory. It reads an active memory, and a slot's shadow contents move into the active memory only when software asks for it.

There are fifteen slots of nine 32-bit words each. Word 0 of a slot is the header: header byte 0 sits in bits 7:0, byte 1 in bits 15:8, byte 2 in bits 23:16 and byte 3 in bits 31:24. Words 1 to 8 carry the 32 payload bytes.

Each slot has two request bits:
- An immediate request copies the slot on the first cycle in which the update lock input is low.
- A frame request copies the slot on the next frame-start pulse.

Each request bit clears itself when its copy completes. A copy moves all nine words of a slot in one cycle. If software writes the data port into a slot in the same cycle that slot is being copied, a sticky conflict flag is set.

The transmitter read port takes one request per cycle, qualified by `tx_req_valid`. It has no back-pressure: every request is accepted, and exactly one cycle later `tx_rsp_valid` rises for one cycle with the data. The transmitter must take the response in that cycle, because the block does not hold it. The register port, lock and frame-start inputs are plain control pins.

Top module: `gp_packet_store`

## Requirements
- R1: After reset the word pointer, both pending masks and the conflict flag read 0, and every active word reads 0 at the transmitter port.
- R2: Writing register 0 loads the word pointer. A value above 134 loads 0 instead. Reading register 0 returns the pointer.
- R3: Each write to register 1 stores the write data in the shadow word at the pointer. The pointer then advances by one, and wraps from 134 to 0. Reading register 1 returns the shadow word at the pointer without moving the pointer.
- R4: A transmitter request for slot s and word w (slot 0..14, word 0..8) returns active word s*9+w one cycle later with `tx_rsp_valid` high for that cycle. An out-of-range slot or word returns 0. `tx_rsp_valid` is low in every cycle after a cycle without a request.
- R5: Shadow writes do not change what the transmitter reads until the slot is copied.
- R6: Writing register 2 sets the immediate request for every slot whose bit is 1 (bit s is slot s). Reading register 2 returns the pending mask. A pending slot is copied, and its bit cleared, at the first clock edge where `upd_lock` is low. While `upd_lock` is high it stays pending and uncopied.
- R7: Writing register 3 sets frame requests with the same bit layout, readable from register 3. A pending slot is copied, and its bit cleared, at the clock edge where `frame_start` is high, and at no other edge.
- R8: All slots whose requests come due on the same edge are copied together. Slots without a due request keep their active contents.
- R9: A data-port write to a slot on the edge where that slot is copied stores into the shadow memory. The active copy receives the shadow contents from before the write. Bit 0 of register 4 is then set and stays set.
- R10: Writing register 4 with bit 1 set clears the conflict flag. Writing it with bit 1 clear leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 pointer, 1 data, 2 immediate, 3 frame, 4 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| upd_lock | input | 1 | Immediate copies wait while high |
| frame_start | input | 1 | One-cycle frame boundary pulse |
| tx_req_valid | input | 1 | Transmitter read request |
| tx_req_slot | input | 4 | Requested slot |
| tx_req_word | input | 4 | Requested word within the slot |
| tx_rsp_valid | output | 1 | Response valid, one cycle after the request |
| tx_rsp_data | output | 32 | Active word returned |

## Verification
The copy path is exercised with four patterns:
- An immediate request held off by the lock and then released. This separates waiting on the lock from copying at once.
- A frame request that idles for several cycles before the pulse. This shows frame requests ignore ordinary cycles.
- Two frame requests served by one pulse while a third slot keeps its earlier contents. This separates a shared copy from one that disturbs other slots.
- A data write timed onto the copy edge of its own slot. This is the only pattern that can show the old value reaching the active memory, the new value staying in the shadow memory, and the flag setting.

Pointer loads above the last word and a data write at word 134 cover the wrap. Out-of-range transmitter requests cover the zero return.

// File: rtl/gp_pkg.sv
package gp_pkg;
  typedef enum logic [2:0] {
    RA_INDEX = 3'd0,
    RA_DATA  = 3'd1,
    RA_IMM   = 3'd2,
    RA_FRM   = 3'd3,
    RA_STAT  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/gp_reg_ctrl.sv
module gp_reg_ctrl #(
  parameter int NUM_SLOTS = 15,
  parameter int WORDS     = 9,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 8,
  parameter int SLOT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [2:0]           addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_SLOTS-1:0] commit_mask,
  output logic [IDX_W-1:0]     idx,
  output logic                 data_we,
  output logic [NUM_SLOTS-1:0] imm_set,
  output logic [NUM_SLOTS-1:0] frm_set,
  output logic                 conflict
);
  import gp_pkg::*;

  localparam int TOTAL = NUM_SLOTS * WORDS;
  localparam int LAST  = TOTAL - 1;

  logic [IDX_W-1:0]  idx_q;
  logic [SLOT_W-1:0] data_slot;
  logic              wr_index, wr_stat, hit, conflict_q;

  assign wr_index  = wr_en && (addr == RA_INDEX);
  assign data_we   = wr_en && (addr == RA_DATA);
  assign wr_stat   = wr_en && (addr == RA_STAT);
  assign imm_set   = (wr_en && (addr == RA_IMM)) ? wdata[NUM_SLOTS-1:0] : '0;
  assign frm_set   = (wr_en && (addr == RA_FRM)) ? wdata[NUM_SLOTS-1:0] : '0;
  assign data_slot = SLOT_W'(idx_q / IDX_W'(WORDS));
  assign hit       = data_we && commit_mask[data_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (wr_index) begin
      if (wdata > DATA_W'(LAST)) idx_q <= '0;
      else                       idx_q <= wdata[IDX_W-1:0];
    end else if (data_we) begin
      if (idx_q == IDX_W'(LAST)) idx_q <= '0;
      else                       idx_q <= idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  conflict_q <= 1'b0;
    else if (hit)                conflict_q <= 1'b1;
    else if (wr_stat && wdata[1]) conflict_q <= 1'b0;
  end

  assign idx      = idx_q;
  assign conflict = conflict_q;

  // R2
  idx_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(LAST));

  // R3
  idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && idx_q == IDX_W'(LAST)) |=> (idx_q == '0));

  // R9
  conflict_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_q && !(wr_stat && wdata[1])) |=> conflict_q);

  // R10
  conflict_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[1] && !hit) |=> !conflict_q);
endmodule

// File: rtl/gp_commit_ctl.sv
module gp_commit_ctl #(
  parameter int NUM_SLOTS = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] imm_set,
  input  logic [NUM_SLOTS-1:0] frm_set,
  input  logic                 upd_lock,
  input  logic                 frame_start,
  output logic [NUM_SLOTS-1:0] imm_pend,
  output logic [NUM_SLOTS-1:0] frm_pend,
  output logic [NUM_SLOTS-1:0] commit_mask
);
  logic [NUM_SLOTS-1:0] imm_q, frm_q, imm_due, frm_due;

  assign imm_due     = upd_lock    ? '0 : imm_q;
  assign frm_due     = frame_start ? frm_q : '0;
  assign commit_mask = imm_due | frm_due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imm_q <= '0;
      frm_q <= '0;
    end else begin
      imm_q <= (imm_q & ~imm_due) | imm_set;
      frm_q <= (frm_q & ~frm_due) | frm_set;
    end
  end

  assign imm_pend = imm_q;
  assign frm_pend = frm_q;

  // R6
  imm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_lock |=> ((imm_q & $past(imm_q)) == $past(imm_q)));

  // R6
  imm_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_lock && imm_set == '0) |=> (imm_q == '0));

  // R7
  frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ((frm_q & $past(frm_q)) == $past(frm_q)));

  // R7
  frm_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frm_set == '0) |=> (frm_q == '0));
endmodule

// File: rtl/gp_store.sv
module gp_store #(
  parameter int NUM_SLOTS = 15,
  parameter int WORDS     = 9,
  parameter int DATA_W    = 32,
  parameter int IDX_W     = 8,
  parameter int SLOT_W    = 4,
  parameter int WORD_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_SLOTS-1:0] commit_mask,
  output logic [DATA_W-1:0]    shadow_rd,
  input  logic                 rd_valid,
  input  logic [SLOT_W-1:0]    rd_slot,
  input  logic [WORD_W-1:0]    rd_word,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data
);
  localparam int TOTAL = NUM_SLOTS * WORDS;

  logic [DATA_W-1:0] shadow_q [TOTAL];
  logic [DATA_W-1:0] active_q [TOTAL];
  logic              rd_in_range;
  logic [IDX_W-1:0]  rd_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) shadow_q[i] <= '0;
    end else if (we) begin
      shadow_q[widx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) active_q[i] <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        for (int w = 0; w < WORDS; w++) begin
          if (commit_mask[s]) active_q[s*WORDS+w] <= shadow_q[s*WORDS+w];
        end
      end
    end
  end

  assign shadow_rd   = shadow_q[widx];
  assign rd_in_range = (rd_slot < SLOT_W'(NUM_SLOTS)) && (rd_word < WORD_W'(WORDS));
  assign rd_idx      = IDX_W'(rd_slot) * IDX_W'(WORDS) + IDX_W'(rd_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_valid;
      if (rd_valid) rsp_data <= rd_in_range ? active_q[rd_idx] : '0;
    end
  end

  // R4
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rsp_valid);

  // R4
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rsp_valid);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_copy_chk
    // R8
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_mask[s] |=> (active_q[s*WORDS] == $past(shadow_q[s*WORDS])));
    // R5
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_mask[s] |=> $stable(active_q[s*WORDS+WORDS-1]));
  end
endmodule

// File: rtl/gp_packet_store.sv
module gp_packet_store #(
  parameter int NUM_SLOTS = 15,
  parameter int WORDS     = 9,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS * WORDS),
  localparam int SLOT_W   = $clog2(NUM_SLOTS + 1),
  localparam int WORD_W   = $clog2(WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              upd_lock,
  input  logic              frame_start,
  input  logic              tx_req_valid,
  input  logic [SLOT_W-1:0] tx_req_slot,
  input  logic [WORD_W-1:0] tx_req_word,
  output logic              tx_rsp_valid,
  output logic [DATA_W-1:0] tx_rsp_data
);
  import gp_pkg::*;

  logic [IDX_W-1:0]     idx;
  logic                 data_we, conflict;
  logic [NUM_SLOTS-1:0] imm_set, frm_set, imm_pend, frm_pend, commit_mask;
  logic [DATA_W-1:0]    shadow_rd;

  gp_reg_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .commit_mask(commit_mask), .idx(idx),
    .data_we(data_we), .imm_set(imm_set), .frm_set(frm_set),
    .conflict(conflict)
  );

  gp_commit_ctl #(.NUM_SLOTS(NUM_SLOTS)) u_commit (
    .clk(clk), .rst_n(rst_n), .imm_set(imm_set), .frm_set(frm_set),
    .upd_lock(upd_lock), .frame_start(frame_start), .imm_pend(imm_pend),
    .frm_pend(frm_pend), .commit_mask(commit_mask)
  );

  gp_store #(
    .NUM_SLOTS(NUM_SLOTS), .WORDS(WORDS), .DATA_W(DATA_W),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .we(data_we), .widx(idx), .wdata(reg_wdata),
    .commit_mask(commit_mask), .shadow_rd(shadow_rd),
    .rd_valid(tx_req_valid), .rd_slot(tx_req_slot), .rd_word(tx_req_word),
    .rsp_valid(tx_rsp_valid), .rsp_data(tx_rsp_data)
  );

  always_comb begin
    case (reg_addr)
      RA_INDEX: reg_rdata = DATA_W'(idx);
      RA_DATA:  reg_rdata = shadow_rd;
      RA_IMM:   reg_rdata = DATA_W'(imm_pend);
      RA_FRM:   reg_rdata = DATA_W'(frm_pend);
      RA_STAT:  reg_rdata = DATA_W'(conflict);
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/sim_gp_packet_store.sv
module sim_gp_packet_store;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr_en = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        upd_lock = 0;
  logic        frame_start = 0;
  logic        tx_req_valid = 0;
  logic [3:0]  tx_req_slot = 0;
  logic [3:0]  tx_req_word = 0;
  logic        tx_rsp_valid;
  logic [31:0] tx_rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] shadow_m [135];
  logic [31:0] active_m [135];
  int          idx_m = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  gp_packet_store u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_lock(upd_lock),
    .frame_start(frame_start), .tx_req_valid(tx_req_valid),
    .tx_req_slot(tx_req_slot), .tx_req_word(tx_req_word),
    .tx_rsp_valid(tx_rsp_valid), .tx_rsp_data(tx_rsp_data)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // monitor: pops the scoreboard as responses appear
  always @(negedge clk) begin
    if (rst_n && tx_rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected response", tx_rsp_data, 32'hxxxxxxxx);
      end else begin
        chk(tag_q.pop_front(), tx_rsp_data, exp_q.pop_front());
      end
    end
  end

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 0;
    if (a == 3'd0) idx_m = (d > 134) ? 0 : int'(d);
    if (a == 3'd1) begin
      shadow_m[idx_m] = d;
      idx_m = (idx_m == 134) ? 0 : idx_m + 1;
    end
  endtask

  task automatic reg_chk(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic tx_rd(string req, int s, int w);
    @(negedge clk);
    tx_req_valid = 1; tx_req_slot = 4'(s); tx_req_word = 4'(w);
    exp_q.push_back((s < 15 && w < 9) ? active_m[s*9+w] : 32'h0);
    tag_q.push_back(req);
    @(posedge clk); #1;
    tx_req_valid = 0;
  endtask

  task automatic tx_slot(string req, int s);
    for (int w = 0; w < 9; w++) tx_rd(req, s, w);
  endtask

  task automatic commit_m(int s);
    for (int w = 0; w < 9; w++) active_m[s*9+w] = shadow_m[s*9+w];
  endtask

  task automatic fill_slot(int s, logic [31:0] seed);
    reg_wr(3'd0, 32'(s*9));
    for (int w = 0; w < 9; w++) reg_wr(3'd1, seed ^ 32'(w * 32'h01010101));
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 135; i++) begin shadow_m[i] = 0; active_m[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    reg_chk("R1 pointer", 3'd0, 0);
    reg_chk("R1 imm pending", 3'd2, 0);
    reg_chk("R1 frame pending", 3'd3, 0);
    reg_chk("R1 conflict", 3'd4, 0);
    tx_rd("R1 active zero", 3, 0);

    // R2 pointer loads
    reg_wr(3'd0, 18);
    reg_chk("R2 pointer load", 3'd0, 18);
    reg_wr(3'd0, 200);
    reg_chk("R2 pointer above last", 3'd0, 0);
    reg_wr(3'd0, 135);
    reg_chk("R2 pointer 135", 3'd0, 0);

    // R3 data port advance; header bytes 0..3 in bits 7:0..31:24
    reg_wr(3'd0, 18);
    reg_wr(3'd1, 32'h44332211);
    for (int w = 1; w < 9; w++) reg_wr(3'd1, 32'hA0000000 + 32'(w));
    reg_chk("R3 pointer advance", 3'd0, 27);
    reg_wr(3'd0, 18);
    reg_chk("R3 shadow readback", 3'd1, 32'h44332211);
    reg_chk("R3 readback keeps pointer", 3'd0, 18);

    // R5 not visible before copy
    tx_rd("R5 uncommitted", 2, 0);

    // R6 immediate request held by lock
    @(negedge clk) upd_lock = 1;
    reg_wr(3'd2, 32'h4);
    reg_chk("R6 pending readback", 3'd2, 32'h4);
    idle(3);
    reg_chk("R6 held by lock", 3'd2, 32'h4);
    tx_rd("R6 no copy under lock", 2, 0);
    @(negedge clk) upd_lock = 0;
    idle(2);
    commit_m(2);
    reg_chk("R6 pending cleared", 3'd2, 0);
    tx_slot("R6 R4 copied slot", 2);

    // R3 wrap at last word
    reg_wr(3'd0, 134);
    reg_wr(3'd1, 32'hCAFE0134);
    reg_chk("R3 pointer wrap", 3'd0, 0);

    // R7 frame requests, R8 two slots on one pulse
    fill_slot(0, 32'h10203040);
    fill_slot(14, 32'h55AA7700);
    reg_wr(3'd3, 32'h4001);
    idle(3);
    reg_chk("R7 frame pending", 3'd3, 32'h4001);
    tx_rd("R7 no copy before pulse", 0, 0);
    @(negedge clk) frame_start = 1;
    @(negedge clk) frame_start = 0;
    commit_m(0); commit_m(14);
    reg_chk("R7 frame pending cleared", 3'd3, 0);
    tx_slot("R8 slot 0 copied", 0);
    tx_slot("R8 slot 14 copied", 14);
    tx_slot("R8 slot 2 untouched", 2);

    // R9 write on copy edge of same slot
    @(negedge clk) upd_lock = 1;
    reg_wr(3'd2, 32'h20);
    reg_wr(3'd0, 45);
    @(negedge clk);
    upd_lock = 0; reg_wr_en = 1; reg_addr = 3'd1; reg_wdata = 32'hDEADBEEF;
    @(posedge clk); #1;
    reg_wr_en = 0;
    commit_m(5);
    shadow_m[45] = 32'hDEADBEEF; idx_m = 46;
    reg_chk("R9 conflict set", 3'd4, 1);
    tx_rd("R9 active has old word", 5, 0);
    reg_wr(3'd0, 45);
    reg_chk("R9 shadow kept write", 3'd1, 32'hDEADBEEF);
    idle(2);
    reg_chk("R9 flag sticky", 3'd4, 1);

    // R10 clear semantics
    reg_wr(3'd4, 32'h1);
    reg_chk("R10 write without clear bit", 3'd4, 1);
    reg_wr(3'd4, 32'h2);
    reg_chk("R10 cleared", 3'd4, 0);

    // copy slot 5 again, no conflict this time
    reg_wr(3'd2, 32'h20);
    idle(2);
    commit_m(5);
    tx_rd("R6 recopy slot 5", 5, 0);
    reg_chk("R9 no conflict on clean copy", 3'd4, 0);

    // R4 out of range
    tx_rd("R4 slot out of range", 15, 0);
    tx_rd("R4 word out of range", 2, 9);

    idle(4);
    chk("R4 scoreboard drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule